// File: doc/BRIEF.md
# Bitmapped GPIO Controller with Per-Pin Interrupt Detection

This block is a register-mapped general purpose I/O controller for up to 94 pins. Software reaches it over a plain single-cycle bus with separate write and read strobes. Each pin has two private configuration words. These hold its output level, direction, mode select, trigger type, trigger inversion, input-sensing disable and a stored weak-pull code. State shared by all pins sits in packed 32-bit bitmaps, one bit per pin: ownership, interrupt status and interrupt enable. A single 32-bit global control word is stored and read back.

Every pin input passes through a synchroniser. When a pin is owned, in GPIO mode and has sensing enabled, it is watched for one of four trigger conditions. A hit latches a write-one-to-clear status bit. The single interrupt output is high whenever any latched status bit has its enable bit set. The controller drives a pad only for a pin in GPIO mode that is configured as an output.

Top module: `gpio_bitmap_ctrl`

## Requirements
- R1: After reset:
  - every config1 word reads 0x00000005 (GPIO mode, input direction);
  - every config2 word reads 0x00000004 (sensing off);
  - ownership bits of existing pins read 1;
  - status, enable and the global word read 0;
  - irq and every pin_oe are 0.
- R2: The address map is as follows. Address bits 1:0 are ignored.
  - Ownership words are at 0x000+4w, status words at 0x080+4w and enable words at 0x090+4w. Pin n uses bit n%32 of word n/32.
  - The global word is at 0x07C. Config1 of pin n is at 0x100+8n and config2 at 0x104+8n.
  - Read data appears on bus_rdata after the clock edge that samples bus_rd, and holds until the next read.
  - Unmapped addresses read 0. Bitmap bits above the pin count read 0 and ignore writes.
- R3: Config1 field layout:
  - bit 31 is the output level and bit 30 is the read-only input level;
  - bit 4 selects level (1) or edge (0) triggering, and bit 3 inverts the trigger;
  - bit 2 is direction (1 = input) and bit 0 is GPIO mode (1) versus native function (0);
  - all other bits read 0.
  - pin_oe[n] is 1 exactly when GPIO mode is 1 and direction is 0. pin_out[n] equals the output level while pin_oe[n] is 1, and is 0 otherwise.
- R4: Config1 bit 30 shows pin_in after a two-flop synchroniser, and reads 0 while config2 bit 2 (sensing off) is 1.
- R5: The trigger mode is set by {bit 4, bit 3} of config1:
  - 00 sets status on a rising edge of the synchronised input;
  - 01 sets status on a falling edge;
  - 10 sets status while the input is low;
  - 11 sets status while the input is high.
  - An input that holds its inactive value sets no status.
- R6: In a level mode, status is set again on every cycle the level condition holds, so clearing it does not stick while the level persists.
- R7: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. An event in the same cycle as the clear keeps the bit set.
- R8: A pin never sets its status bit while its ownership bit is 0, its GPIO mode bit is 0, or its sensing-off bit is 1.
- R9: irq is 1 exactly when some status bit and its matching enable bit are both 1. It follows the registered bitmaps with no further delay.
- R10: Config2 bits 1:0 (weak pull) and bit 2 are stored and read back, and its other bits read 0. The global word stores and returns all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Pad input levels |
| pin_out | output | NUM_PINS | Pad output levels |
| pin_oe | output | NUM_PINS | Pad output enables |
| irq | output | 1 | Aggregated interrupt |

## Verification
The hardest situation to reach is a status clear that lands while a level condition still holds. The clear must lose to the event arriving in the same cycle, yet an edge-mode pin must clear for good. The bench reaches this by driving each randomly chosen pin into its active level and leaving it there, then issuing the write-one-to-clear and reading status straight back. The same clear is applied in all four trigger modes. A further difficulty is keeping stray status from neighbouring pins in the same packed word. The bench turns sensing off on each pin once it has finished with it, so every status word read has exactly one expected bit.

// File: rtl/gbc_pkg.sv
package gbc_pkg;
   localparam int WORD_W      = 32;
   localparam int OWN_BASE    = 'h000;
   localparam int GCTL_ADDR   = 'h07C;
   localparam int STAT_BASE   = 'h080;
   localparam int ENA_BASE    = 'h090;
   localparam int CFG_BASE    = 'h100;
   localparam int MAX_PINS    = 94;

   // config1 bit positions
   localparam int C1_OUT  = 31;
   localparam int C1_IN   = 30;
   localparam int C1_TLVL = 4;
   localparam int C1_TINV = 3;
   localparam int C1_DIR  = 2;
   localparam int C1_USE  = 0;
   // config2 bit positions
   localparam int C2_OFF  = 2;

   typedef struct packed {
      logic out_lvl;
      logic trig_lvl;
      logic trig_inv;
      logic dir_in;
      logic use_gpio;
   } cfg1_t;

   typedef struct packed {
      logic       sense_off;
      logic [1:0] pull;
   } cfg2_t;

   function automatic int words_for(int n);
      return (n + WORD_W - 1) / WORD_W;
   endfunction

   function automatic logic [WORD_W-1:0] word_mask(int n, int w);
      logic [WORD_W-1:0] m;
      m = '0;
      for (int b = 0; b < WORD_W; b++)
         if (w * WORD_W + b < n) m[b] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/gbc_pin_slice.sv
module gbc_pin_slice
   import gbc_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg1_we,
   input  logic        cfg2_we,
   input  logic [31:0] wdata,
   input  logic        pad_in,
   input  logic        owned,
   output logic [31:0] cfg1_rd,
   output logic [31:0] cfg2_rd,
   output logic        trig_evt,
   output logic        pad_out,
   output logic        pad_oe
);
   initial begin
      sync_stages_chk: assert (SYNC_STAGES >= 2);
   end

   cfg1_t                  c1_q;
   cfg2_t                  c2_q;
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   synced;
   logic                   active;
   logic                   hit;
   logic                   unused_wbits;

   assign unused_wbits = ^{wdata[30:5], wdata[1]};
   assign synced       = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c1_q   <= '{out_lvl: 1'b0, trig_lvl: 1'b0, trig_inv: 1'b0,
                     dir_in: 1'b1, use_gpio: 1'b1};
         c2_q   <= '{sense_off: 1'b1, pull: 2'b00};
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         if (cfg1_we)
            c1_q <= '{out_lvl: wdata[C1_OUT], trig_lvl: wdata[C1_TLVL],
                      trig_inv: wdata[C1_TINV], dir_in: wdata[C1_DIR],
                      use_gpio: wdata[C1_USE]};
         if (cfg2_we)
            c2_q <= '{sense_off: wdata[C2_OFF], pull: wdata[1:0]};
         sync_q <= {sync_q[SYNC_STAGES-2:0], pad_in};
         prev_q <= synced;
      end
   end

   always_comb begin
      unique case ({c1_q.trig_lvl, c1_q.trig_inv})
         2'b00:   hit = synced & ~prev_q;
         2'b01:   hit = ~synced & prev_q;
         2'b10:   hit = ~synced;
         default: hit = synced;
      endcase
   end

   assign active   = owned & c1_q.use_gpio & ~c2_q.sense_off;
   assign trig_evt = active & hit;
   assign pad_oe   = c1_q.use_gpio & ~c1_q.dir_in;
   assign pad_out  = c1_q.out_lvl & pad_oe;

   assign cfg1_rd = {c1_q.out_lvl, synced & ~c2_q.sense_off, 25'b0,
                     c1_q.trig_lvl, c1_q.trig_inv, c1_q.dir_in, 1'b0,
                     c1_q.use_gpio};
   assign cfg2_rd = {29'b0, c2_q.sense_off, c2_q.pull};

   // R5
   edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!c1_q.trig_lvl && synced == prev_q) |-> !trig_evt);

   // R8
   sense_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c2_q.sense_off |-> !trig_evt);
endmodule

// File: rtl/gbc_bitmap_bank.sv
module gbc_bitmap_bank
   import gbc_pkg::*;
#(
   parameter int NUM_PINS = 94,
   localparam int NW      = words_for(NUM_PINS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NW-1:0]          own_we,
   input  logic [NW-1:0]          stat_we,
   input  logic [NW-1:0]          ena_we,
   input  logic [31:0]            wdata,
   input  logic [NUM_PINS-1:0]    evt,
   output logic [NUM_PINS-1:0]    own_bits,
   output logic [NW-1:0][31:0]    own_w,
   output logic [NW-1:0][31:0]    stat_w,
   output logic [NW-1:0][31:0]    ena_w,
   output logic                   irq
);
   logic [NW*32-1:0] evt_pad;
   logic [NW*32-1:0] own_flat;

   always_comb begin
      evt_pad                = '0;
      evt_pad[NUM_PINS-1:0]  = evt;
   end

   for (genvar w = 0; w < NW; w++) begin : g_word
      localparam logic [31:0] WMASK = word_mask(NUM_PINS, w);
      logic [31:0] evt_w;
      logic [31:0] clr_w;

      assign evt_w = evt_pad[w*32 +: 32];
      assign clr_w = stat_we[w] ? wdata : 32'h0;
      assign own_flat[w*32 +: 32] = own_w[w];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            own_w[w]  <= WMASK;
            stat_w[w] <= '0;
            ena_w[w]  <= '0;
         end else begin
            if (own_we[w]) own_w[w] <= wdata & WMASK;
            if (ena_we[w]) ena_w[w] <= wdata & WMASK;
            stat_w[w] <= ((stat_w[w] & ~clr_w) | evt_w) & WMASK;
         end
      end

      // R7
      stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !stat_we[w] |=> ((stat_w[w] & $past(stat_w[w])) == $past(stat_w[w])));

      // R7
      stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_we[w] && wdata == 32'hFFFF_FFFF && evt_w == 32'h0)
         |=> (stat_w[w] == 32'h0));

      // R8
      stat_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> ((stat_w[w] & ~$past(stat_w[w]) & ~$past(own_w[w])) == 32'h0));
   end

   assign own_bits = own_flat[NUM_PINS-1:0];

   always_comb begin
      irq = 1'b0;
      for (int w = 0; w < NW; w++)
         irq = irq | (|(stat_w[w] & ena_w[w]));
   end
endmodule

// File: rtl/gpio_bitmap_ctrl.sv
module gpio_bitmap_ctrl
   import gbc_pkg::*;
#(
   parameter int NUM_PINS    = 94,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                irq
);
   localparam int NW    = words_for(NUM_PINS);
   localparam int IDX_W = ADDR_W - 3;

   initial begin
      param_range_chk: assert (NUM_PINS >= 1 && NUM_PINS <= MAX_PINS);
      addr_width_chk:  assert (ADDR_W >= 12);
   end

   logic [ADDR_W-1:0] a_w;
   logic [ADDR_W-1:0] cfg_rel;
   logic [IDX_W-1:0]  cfg_idx;
   logic [1:0]        widx;
   logic              own_hit, stat_hit, ena_hit, gctl_hit, cfg_hit;
   logic              unused_lane;
   logic [31:0]       gctl_q;
   logic [31:0]       rd_mux;

   assign a_w      = {bus_addr[ADDR_W-1:2], 2'b00};
   assign cfg_rel  = a_w - ADDR_W'(CFG_BASE);
   assign cfg_idx  = cfg_rel[ADDR_W-1:3];
   assign widx     = a_w[3:2];
   assign unused_lane = ^{bus_addr[1:0], cfg_rel[1:0]};

   assign own_hit  = a_w < ADDR_W'(OWN_BASE + 4 * NW);
   assign stat_hit = a_w >= ADDR_W'(STAT_BASE) && a_w < ADDR_W'(STAT_BASE + 4 * NW);
   assign ena_hit  = a_w >= ADDR_W'(ENA_BASE)  && a_w < ADDR_W'(ENA_BASE + 4 * NW);
   assign gctl_hit = a_w == ADDR_W'(GCTL_ADDR);
   assign cfg_hit  = a_w >= ADDR_W'(CFG_BASE) && a_w < ADDR_W'(CFG_BASE + 8 * NUM_PINS);

   logic [NW-1:0]         own_we, stat_we, ena_we;
   logic [NW-1:0][31:0]   own_w, stat_w, ena_w;
   logic [NUM_PINS-1:0]   own_bits;
   logic [NUM_PINS-1:0]   evt;
   logic [31:0]           c1_rd [NUM_PINS];
   logic [31:0]           c2_rd [NUM_PINS];

   for (genvar w = 0; w < NW; w++) begin : g_wdec
      assign own_we[w]  = bus_wr & own_hit  & (widx == 2'(w));
      assign stat_we[w] = bus_wr & stat_hit & (widx == 2'(w));
      assign ena_we[w]  = bus_wr & ena_hit  & (widx == 2'(w));
   end

   gbc_bitmap_bank #(.NUM_PINS(NUM_PINS)) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .own_we   (own_we),
      .stat_we  (stat_we),
      .ena_we   (ena_we),
      .wdata    (bus_wdata),
      .evt      (evt),
      .own_bits (own_bits),
      .own_w    (own_w),
      .stat_w   (stat_w),
      .ena_w    (ena_w),
      .irq      (irq)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic sel;
      assign sel = bus_wr & cfg_hit & (cfg_idx == IDX_W'(p));

      gbc_pin_slice #(.SYNC_STAGES(SYNC_STAGES)) slice_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg1_we  (sel & ~cfg_rel[2]),
         .cfg2_we  (sel & cfg_rel[2]),
         .wdata    (bus_wdata),
         .pad_in   (pin_in[p]),
         .owned    (own_bits[p]),
         .cfg1_rd  (c1_rd[p]),
         .cfg2_rd  (c2_rd[p]),
         .trig_evt (evt[p]),
         .pad_out  (pin_out[p]),
         .pad_oe   (pin_oe[p])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 gctl_q <= '0;
      else if (bus_wr && gctl_hit) gctl_q <= bus_wdata;
   end

   always_comb begin
      rd_mux = '0;
      if (gctl_hit) rd_mux = gctl_q;
      for (int w = 0; w < NW; w++) begin
         if (own_hit  && widx == 2'(w)) rd_mux = own_w[w];
         if (stat_hit && widx == 2'(w)) rd_mux = stat_w[w];
         if (ena_hit  && widx == 2'(w)) rd_mux = ena_w[w];
      end
      for (int p = 0; p < NUM_PINS; p++)
         if (cfg_hit && cfg_idx == IDX_W'(p))
            rd_mux = cfg_rel[2] ? c2_rd[p] : c1_rd[p];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   // R2
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   // R9
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ena_w != '0));
endmodule

// File: tb/gpio_bitmap_ctrl_tb_top.sv
module gpio_bitmap_ctrl_tb_top;
   localparam int N = 94;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  pins_v = '0;
   logic [N-1:0]  pin_out;
   logic [N-1:0]  pin_oe;
   logic          irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   gpio_bitmap_ctrl #(.NUM_PINS(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pins_v), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   function automatic logic [11:0] c1a(int p); return 12'(32'h100 + 8 * p); endfunction
   function automatic logic [11:0] c2a(int p); return 12'(32'h104 + 8 * p); endfunction
   function automatic logic [11:0] sta(int p); return 12'(32'h080 + 4 * (p / 32)); endfunction
   function automatic logic [11:0] ena(int p); return 12'(32'h090 + 4 * (p / 32)); endfunction
   function automatic logic [11:0] owa(int p); return 12'(32'h000 + 4 * (p / 32)); endfunction
   function automatic logic [31:0] bitof(int p); return 32'h1 << (p % 32); endfunction
   function automatic logic [31:0] exp_mask(int w);
      logic [31:0] m = '0;
      for (int b = 0; b < 32; b++) if (w * 32 + b < N) m[b] = 1'b1;
      return m;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      if (!done) $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int unsigned s;
      s = $urandom(32'd7341);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", {31'b0, irq}, 32'h0);
      chk("R1 oe", {31'b0, |pin_oe}, 32'h0);
      rd(c1a(0), d);  chk("R1 cfg1", d, 32'h0000_0005);
      rd(c2a(93), d); chk("R1 cfg2", d, 32'h0000_0004);
      rd(owa(0), d);  chk("R1 own0", d, 32'hFFFF_FFFF);
      rd(owa(64), d); chk("R1 own2", d, exp_mask(2));
      rd(sta(0), d);  chk("R1 stat", d, 32'h0);
      rd(ena(40), d); chk("R1 ena", d, 32'h0);
      rd(12'h07C, d); chk("R1 gctl", d, 32'h0);

      // R2 / R10 map and unused bits
      wr(12'h07C, 32'hA5A5_1234); rd(12'h07C, d); chk("R10 gctl", d, 32'hA5A5_1234);
      wr(ena(64), 32'hFFFF_FFFF); rd(ena(64), d); chk("R2 ena hi bits", d, exp_mask(2));
      wr(ena(64), 32'h0);
      rd(12'h040, d); chk("R2 unmapped", d, 32'h0);
      rd(c1a(N), d);  chk("R2 past pins", d, 32'h0);
      wr(c2a(5), 32'hFFFF_FFFF); rd(c2a(5), d); chk("R10 cfg2", d, 32'h7);
      wr(c2a(5), 32'h4);

      // R3 fields and pad drive
      wr(c1a(7), 32'hFFFF_FFFF); rd(c1a(7), d); chk("R3 cfg1 fields", d, 32'h8000_001D);
      chk("R3 oe input", {31'b0, pin_oe[7]}, 32'h0);
      wr(c1a(7), 32'h8000_0001);
      chk("R3 oe out", {30'b0, pin_oe[7], pin_out[7]}, 32'h3);
      wr(c1a(7), 32'h0000_0001);
      chk("R3 out low", {30'b0, pin_oe[7], pin_out[7]}, 32'h2);
      wr(c1a(7), 32'h8000_0000);
      chk("R3 native", {30'b0, pin_oe[7], pin_out[7]}, 32'h0);
      wr(c1a(7), 32'h5);

      // R4 input level
      @(negedge clk); pins_v[10] = 1'b1; settle();
      rd(c1a(10), d); chk("R4 level sense off", d, 32'h5);
      wr(c2a(10), 32'h0); rd(c1a(10), d); chk("R4 level", d, 32'h4000_0005);
      @(negedge clk); pins_v[10] = 1'b0; settle();
      rd(c1a(10), d); chk("R4 level low", d, 32'h5);
      wr(c2a(10), 32'h4); wr(sta(10), 32'hFFFF_FFFF);

      // R8 gating: ownership, native mode, sense off
      wr(owa(40), ~bitof(40)); wr(c2a(40), 32'h0);
      @(negedge clk); pins_v[40] = 1'b1; settle();
      rd(sta(40), d); chk("R8 not owned", d, 32'h0);
      wr(c2a(40), 32'h4); wr(owa(40), 32'hFFFF_FFFF);
      wr(c1a(41), 32'h4); wr(c2a(41), 32'h0);
      @(negedge clk); pins_v[41] = 1'b1; settle();
      rd(sta(41), d); chk("R8 native mode", d, 32'h0);
      wr(c2a(41), 32'h4); wr(c1a(41), 32'h5);
      @(negedge clk); pins_v[42] = 1'b1; settle();
      rd(sta(42), d); chk("R8 sense off", d, 32'h0);
      @(negedge clk); pins_v[40] = 1'b0; pins_v[41] = 1'b0; pins_v[42] = 1'b0; settle();

      // R7 write zero, R9 irq
      wr(c2a(50), 32'h0);
      @(negedge clk); pins_v[50] = 1'b1; settle();
      wr(sta(50), 32'h0); rd(sta(50), d); chk("R7 write zero", d, bitof(50));
      chk("R9 irq masked", {31'b0, irq}, 32'h0);
      wr(ena(50), bitof(50)); chk("R9 irq on", {31'b0, irq}, 32'h1);
      wr(sta(50), bitof(50)); rd(sta(50), d); chk("R7 clear", d, 32'h0);
      chk("R9 irq off", {31'b0, irq}, 32'h0);
      wr(ena(50), 32'h0); wr(c2a(50), 32'h4);
      @(negedge clk); pins_v[50] = 1'b0; settle();

      // R5 / R6 / R9 random pins and modes
      for (int it = 0; it < 40; it++) begin
         int p;
         int mode;
         bit en;
         bit start;
         p     = $urandom_range(0, N - 1);
         mode  = $urandom_range(0, 3);
         en    = 1'($urandom_range(0, 1));
         start = (mode == 1 || mode == 2);
         @(negedge clk); pins_v[p] = start;
         wr(c1a(p), 32'(mode << 3) | 32'h5);
         wr(c2a(p), 32'h0);
         settle();
         wr(ena(p), en ? bitof(p) : 32'h0);
         wr(sta(p), 32'hFFFF_FFFF);
         rd(sta(p), d); chk("R5 idle no event", d, 32'h0);
         @(negedge clk); pins_v[p] = ~start; settle();
         rd(sta(p), d); chk("R5 trigger", d, bitof(p));
         chk("R9 irq follows enable", {31'b0, irq}, {31'b0, en});
         wr(sta(p), bitof(p));
         rd(sta(p), d);
         chk((mode >= 2) ? "R6 level re-sets" : "R7 edge cleared", d,
             (mode >= 2) ? bitof(p) : 32'h0);
         wr(c2a(p), 32'h4);
         wr(sta(p), 32'hFFFF_FFFF);
         wr(ena(p), 32'h0);
         @(negedge clk); pins_v[p] = 1'b0;
         settle();
         rd(sta(p), d); chk("R8 quiet after sense off", d, 32'h0);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule